// File: doc/BRIEF.md
# Receive Byte-Lane Comma Aligner

This block sits in a receive datapath after symbol decoding. Each input word carries four bytes, and each byte has a flag that marks it as a control (K) character. Byte 0 is the earliest byte in time. The stream arrives with an unknown byte-lane phase. The block finds the comma (the K28.5 control character, 0xBC with its control flag set) and rotates the byte lanes so that each comma lands in byte 0 of an output word. The control flags are rotated with their bytes.

The block keeps the last accepted input word and a lane offset. Each output word is built from a window made of the held word followed by the incoming word. The output starts at the offset lane, so its upper bytes come from the incoming word. The offset changes only when an accepted word contains a comma that starts a new run. A run of commas that spans a word boundary therefore stays aligned to its first comma in time. The stream interface is valid/ready on both sides. There is no buffering: output valid is the input valid, and input ready is the output ready.

Top module: `comma_lane_aligner`

## Requirements
- R1: A byte in lane i (bits 8i+7:8i, lane 0 earliest) is a comma only when it equals 0xBC and ctrl bit i is set. 0xBC without its flag, or a flagged byte of any other value, does not move the offset.
- R2: With offset k, out_data_o holds bytes k..3 of the held word followed by bytes 0..k-1 of the current input word.
- R3: After an accepted word whose comma run starts in lane k, the next output word has 0xBC in byte 0 with out_ctrl_o bit 0 set.
- R4: out_ctrl_o is formed from the held and current ctrl nibbles with the same lane rotation as the data.
- R5: A comma counts as a run start only when the byte just before it in time is not a comma. The byte before lane 0 is lane 3 of the held word. For example, a word with ctrl 0xE (data 0xBCBCBC00) followed by ctrl 0x1 (data 0x070605BC) yields an output word 0xBCBCBCBC with ctrl 0xF, and the offset stays 1.
- R6: A comma starting in lane 0 sets offset 0. Each word then comes out unchanged during the next accepted beat.
- R7: The offset changes only on an accepted word (in_valid_i and out_ready_i both high) that contains a run-start comma. It holds through idle cycles, stalled cycles and comma-free words.
- R8: When a word has several run starts, the lowest lane wins.
- R9: out_valid_o follows in_valid_i and in_ready_o follows out_ready_i. The held word advances only on an accepted beat.
- R10: While reset is asserted, the held word and the offset are cleared, so an all-zero input gives an all-zero output with ctrl 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 32 | Input bytes, lane 0 in bits 7:0 |
| in_ctrl_i | input | 4 | K flag per input byte |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 32 | Aligned bytes |
| out_ctrl_o | output | 4 | K flag per aligned byte |

## Verification
The bench places commas in each of the four lanes in turn and checks the rotation at every offset. A design that chose the wrong half of the window would produce bytes from the wrong word. The runs 0xE/0x1, 0xC/0x3 and 0x8/0x7 cross word boundaries. A design that realigned on every comma would jump to offset 0 on the second word and split the run. Further cases check that 0xBC without its flag and a flagged non-comma leave the offset alone, and that a word with two separate commas aligns to the lower one. A comma word offered during a stall or with valid low must not take effect. A design that updated on valid alone would shift the following words.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam logic [7:0]  COMMA_DEF  = 8'hBC;
endpackage

// File: rtl/cla_comma_detect.sv
module cla_comma_detect #(
  parameter int unsigned LANES  = cla_pkg::LANES_DEF,
  parameter int unsigned BYTE_W = cla_pkg::BYTE_W_DEF,
  parameter logic [BYTE_W-1:0] COMMA = cla_pkg::COMMA_DEF,
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] ctrl_i,
  input  logic             prev_last_comma_i,
  output logic             found_o,
  output logic [OFF_W-1:0] lane_o
);
  logic [LANES-1:0] is_comma;
  logic [LANES-1:0] run_start;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign is_comma[g] = ctrl_i[g] && (data_i[g*BYTE_W +: BYTE_W] == COMMA);
    if (g == 0) begin : g_first
      assign run_start[g] = is_comma[g] && !prev_last_comma_i;
    end else begin : g_rest
      assign run_start[g] = is_comma[g] && !is_comma[g-1];
    end
  end

  // lowest start lane wins
  always_comb begin
    lane_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (run_start[i]) lane_o = OFF_W'(i);
    end
  end

  assign found_o = |run_start;
endmodule

// File: rtl/cla_lane_shift.sv
module cla_lane_shift #(
  parameter int unsigned LANES  = cla_pkg::LANES_DEF,
  parameter int unsigned BYTE_W = cla_pkg::BYTE_W_DEF,
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0]    old_data_i,
  input  logic [LANES-1:0] old_ctrl_i,
  input  logic [DW-1:0]    new_data_i,
  input  logic [LANES-1:0] new_ctrl_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [DW-1:0]    data_o,
  output logic [LANES-1:0] ctrl_o
);
  logic [2*DW-1:0]    win_d;
  logic [2*LANES-1:0] win_c;

  assign win_d = {new_data_i, old_data_i};
  assign win_c = {new_ctrl_i, old_ctrl_i};

  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [OFF_W:0] src;
    assign src = (OFF_W+1)'(j) + {1'b0, off_i};
    assign data_o[j*BYTE_W +: BYTE_W] = win_d[src*BYTE_W +: BYTE_W];
    assign ctrl_o[j] = win_c[src];
  end
endmodule

// File: rtl/comma_lane_aligner.sv
module comma_lane_aligner #(
  parameter int unsigned LANES  = cla_pkg::LANES_DEF,
  parameter int unsigned BYTE_W = cla_pkg::BYTE_W_DEF,
  parameter logic [BYTE_W-1:0] COMMA = cla_pkg::COMMA_DEF,
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [DW-1:0]    in_data_i,
  input  logic [LANES-1:0] in_ctrl_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [DW-1:0]    out_data_o,
  output logic [LANES-1:0] out_ctrl_o
);
  logic [DW-1:0]    held_data_q;
  logic [LANES-1:0] held_ctrl_q;
  logic [OFF_W-1:0] off_q;
  logic             fire;
  logic             held_last_comma;
  logic             start_found;
  logic [OFF_W-1:0] start_lane;

  assign fire        = in_valid_i && out_ready_i;
  assign in_ready_o  = out_ready_i;
  assign out_valid_o = in_valid_i;
  assign held_last_comma = held_ctrl_q[LANES-1] &&
                           (held_data_q[DW-1 -: BYTE_W] == COMMA);

  cla_comma_detect #(.LANES(LANES), .BYTE_W(BYTE_W), .COMMA(COMMA)) u_detect (
    .data_i            (in_data_i),
    .ctrl_i            (in_ctrl_i),
    .prev_last_comma_i (held_last_comma),
    .found_o           (start_found),
    .lane_o            (start_lane)
  );

  cla_lane_shift #(.LANES(LANES), .BYTE_W(BYTE_W)) u_shift (
    .old_data_i (held_data_q),
    .old_ctrl_i (held_ctrl_q),
    .new_data_i (in_data_i),
    .new_ctrl_i (in_ctrl_i),
    .off_i      (off_q),
    .data_o     (out_data_o),
    .ctrl_o     (out_ctrl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_data_q <= '0;
      held_ctrl_q <= '0;
      off_q       <= '0;
    end else if (fire) begin
      held_data_q <= in_data_i;
      held_ctrl_q <= in_ctrl_i;
      if (start_found) off_q <= start_lane;
    end
  end

  // R7
  offset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire && start_found) |=> $stable(off_q));

  // R3
  comma_lands_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && start_found) |=> (out_data_o[BYTE_W-1:0] == COMMA) && out_ctrl_o[0]);

  // R6
  lane0_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && start_found && start_lane == '0) |=>
      (out_data_o == $past(in_data_i)) && (out_ctrl_o == $past(in_ctrl_i)));

  // R9
  stall_keeps_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(out_data_o[BYTE_W-1:0]) && $stable(out_ctrl_o[0]));
endmodule

// File: tb/comma_lane_aligner_test.sv
module comma_lane_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic [3:0]  in_ctrl_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic [3:0]  out_ctrl_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] q_d[$];
  logic [3:0]  q_c[$];
  string       q_tag[$];

  logic [31:0] m_prev_d = '0;
  logic [3:0]  m_prev_c = '0;
  int          m_off = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  comma_lane_aligner uut (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_data_i, .in_ctrl_i,
    .out_valid_o, .out_ready_i, .out_data_o, .out_ctrl_o
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_k(logic [31:0] d, logic [3:0] c, int i);
    return c[i] && (d[8*i +: 8] == 8'hBC);
  endfunction

  task automatic send(input logic [31:0] d, input logic [3:0] c, input string tag);
    logic [63:0] wd;
    logic [7:0]  wc;
    bit prev_k;
    int lane;
    @(negedge clk_i);
    in_valid_i = 1'b1; out_ready_i = 1'b1; in_data_i = d; in_ctrl_i = c;
    wd = {d, m_prev_d} >> (8 * m_off);
    wc = {c, m_prev_c} >> m_off;
    q_d.push_back(wd[31:0]); q_c.push_back(wc[3:0]); q_tag.push_back(tag);
    lane = -1;
    prev_k = is_k(m_prev_d, m_prev_c, 3);
    for (int i = 0; i < 4; i++) begin
      if (lane < 0 && is_k(d, c, i) && !prev_k) lane = i;
      prev_k = is_k(d, c, i);
    end
    if (lane >= 0) m_off = lane;
    m_prev_d = d; m_prev_c = c;
    @(posedge clk_i);
  endtask

  task automatic idle(input logic [31:0] d, input logic [3:0] c);
    @(negedge clk_i);
    in_valid_i = 1'b0; out_ready_i = 1'b1; in_data_i = d; in_ctrl_i = c;
    #2 check(out_valid_o == 1'b0, "R9 valid low", {35'd0, out_valid_o}, 36'd0);
    @(posedge clk_i);
  endtask

  task automatic stall(input logic [31:0] d, input logic [3:0] c);
    @(negedge clk_i);
    in_valid_i = 1'b1; out_ready_i = 1'b0; in_data_i = d; in_ctrl_i = c;
    #2;
    check(in_ready_o == 1'b0, "R9 ready follows", {35'd0, in_ready_o}, 36'd0);
    check(out_valid_o == 1'b1, "R9 valid follows", {35'd0, out_valid_o}, 36'd1);
    @(posedge clk_i);
  endtask

  // monitor: compare on every accepted beat
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni && in_valid_i && out_ready_i) begin
        if (q_d.size() == 0) begin
          check(1'b0, "scoreboard empty", '0, '0);
        end else begin
          logic [31:0] ed;
          logic [3:0]  ec;
          string t;
          ed = q_d.pop_front(); ec = q_c.pop_front(); t = q_tag.pop_front();
          check(out_data_o == ed, {t, " data"}, {4'd0, out_data_o}, {4'd0, ed});
          check(out_ctrl_o == ec, {t, " ctrl R4"}, {32'd0, out_ctrl_o}, {32'd0, ec});
          check(in_ready_o && out_valid_o, "R9 handshake", {34'd0, in_ready_o, out_valid_o}, 36'd3);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10 reset state
    check(out_data_o == 32'h0 && out_ctrl_o == 4'h0, "R10 reset",
          {out_ctrl_o, out_data_o}, 36'd0);
    rst_ni = 1'b1;
    @(posedge clk_i);

    // R6 lane 0 comma, pass-through
    send(32'h030201BC, 4'h1, "R10 first beat");
    send(32'h07060504, 4'h0, "R6 lane0");
    send(32'h0B0A0908, 4'h0, "R6 lane0");
    send(32'h0F0E0D0C, 4'h0, "R6 lane0");
    // R2 R3 lane 1
    send(32'h0201BC07, 4'h2, "R2 pre");
    send(32'h0605040B, 4'h0, "R3 lane1");
    send(32'h0A09080F, 4'h0, "R2 lane1");
    // R2 lane 2, lane 3
    send(32'h9CBC1F01, 4'h4, "R2 pre2");
    send(32'h0300202F, 4'h0, "R3 lane2");
    send(32'h8D03A500, 4'h0, "R2 lane2");
    send(32'hBC878685, 4'h8, "R2 pre3");
    send(32'h848B8A89, 4'h0, "R3 lane3");
    send(32'h888F8E8D, 4'h0, "R2 lane3");
    // R5 boundary-crossing runs
    send(32'hBCBCBC00, 4'hE, "R5 run e");
    send(32'h070605BC, 4'h1, "R5 e1 word");
    send(32'h0B0A0908, 4'h0, "R5 hold off1");
    send(32'hBCBC0000, 4'hC, "R5 run c");
    send(32'h0706BCBC, 4'h3, "R5 c3 word");
    send(32'h0B0A0908, 4'h0, "R5 hold off2");
    send(32'hBC000000, 4'h8, "R5 run 8");
    send(32'h07BCBCBC, 4'h7, "R5 87 word");
    send(32'h0B0A0908, 4'h0, "R5 hold off3");
    // R1 non-commas
    send(32'h11BC2233, 4'h0, "R1 unflagged bc");
    send(32'h4455667C, 4'h1, "R1 flagged other");
    send(32'h8899AABB, 4'h0, "R1 offset kept");
    // R8 two separate commas: lanes 1 and 3
    send(32'hBC22BC11, 4'hA, "R8 pre");
    send(32'h55443322, 4'h0, "R8 lowest");
    // R7 idle and stall with comma words
    idle(32'h000000BC, 4'h1);
    stall(32'h0000BC00, 4'h2);
    send(32'h0D0C0B0A, 4'h0, "R7 after stall");
    send(32'h11100F0E, 4'h0, "R7 offset held");
    send(32'h000000BC, 4'h1, "R6 realign");
    send(32'h15141312, 4'h0, "R6 lane0 again");
    idle(32'h0, 4'h0);
    check(q_d.size() == 0, "R9 scoreboard drained", 36'(q_d.size()), 36'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule